// File: doc/BRIEF.md
# Bus Arbitration and Target Selection Sequencer

This block is the initiator side of an 8-line parallel peripheral bus. Each device on the bus owns one data line as its ID bit. A single start command runs the whole sequence. The block first waits for the bus to go free. It then arbitrates by driving BSY and its own ID bit, checks whether a higher-priority device is also present, and, once it has won, selects one target. It can raise ATN during selection so that the target expects a message before the command. The command, data and message phases that follow belong to other logic.

Every bus output models an open-collector line: a high output means the line is pulled to its asserted level. The bench or the pad logic wire-ORs these outputs with the other devices, and the block samples the resulting bus. Settle delays and timeouts are counted in clock cycles set by parameters. The selection timeout is given in milliseconds on an input pin and converted using a cycles-per-millisecond parameter.

There is no streaming data here. Start, the ID inputs and the result pins are plain level and pulse signals, with no back-pressure. A start arriving while a sequence is running is ignored.

Top module: `busarb_initiator`

## Requirements
- R1: After reset, BSY, SEL, ATN, the data output enable and done are all low, and the data output is zero.
- R2: While the sampled bus shows BSY or SEL, the block drives no line. If the bus has not gone free within ARB_TMO_CYC cycles of the start or of the latest retry, it pulses done with error code 1 and leaves all lines released.
- R3: Once the bus is seen free, the block asserts BSY and drives only its own ID bit on the data lines, with the output enable high.
- R4: If SEL is sampled from another device at any time between the start of arbitration and the second lost check, the block releases its lines and returns to waiting for a free bus. No error is reported.
- R5: After one settle delay of arbitration, the block XORs the sampled data bus with its own ID bit and treats the result as unsigned. If the result is larger than its own ID bit, a higher-priority device is present and the block retries. Otherwise it goes on to selection.
- R6: Selection drives SEL and BSY together with the data value (1 << target ID) | own ID bit. Target ID is a 3-bit binary number, so bit n is data line n. ATN rises together with SEL if, and only if, attention was requested at start.
- R7: After one settle delay, the block releases BSY but keeps SEL, the data value and ATN. It then waits for the target to assert BSY.
- R8: When the target asserts BSY within timeout_ms × CYC_PER_MS cycles, the block waits one settle delay, releases SEL and the data lines, and pulses done with error code 0. A requested ATN stays asserted until the next start.
- R9: If no target BSY arrives within timeout_ms × CYC_PER_MS cycles, the block releases all lines, including ATN, and pulses done with error code 2.
- R10: Done is high for exactly one cycle per start. The error code is nonzero only while done is high. A start received while a sequence is in progress has no effect.
- R11: Arbitration losses are retried without limit. Each retry restarts the free-bus timeout, so a long run of losses never produces an error on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a sequence when idle (one-cycle pulse) |
| own_id_i | input | 8 | Own ID as a one-hot data-line bit, latched at start |
| tgt_id_i | input | 3 | Target ID number, latched at start |
| atn_req_i | input | 1 | Request ATN during selection, latched at start |
| sel_tmo_ms_i | input | 16 | Selection timeout in milliseconds, latched at start |
| bus_bsy_i | input | 1 | Sampled BSY line (wire-OR of all devices) |
| bus_sel_i | input | 1 | Sampled SEL line |
| bus_data_i | input | 8 | Sampled data lines |
| bsy_o | output | 1 | Assert BSY |
| sel_o | output | 1 | Assert SEL |
| atn_o | output | 1 | Assert ATN |
| data_o | output | 8 | Value driven on the data lines |
| data_oe_o | output | 1 | Data-line output enable |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result code with done: 0 ok, 1 arbitration timeout, 2 selection timeout |

## Verification
A wrong latched ID or target shows at once in the value driven on the data lines, both on the cycle BSY rises and on the cycle SEL rises. A stuck lost-arbitration flag or a wrong priority compare shows as BSY pulsing through retries with no SEL, or as SEL appearing while a higher ID is on the bus. A wrong timer load shows up as done arriving too early, which the bench catches by counting cycles against the free-bus and millisecond windows. A leftover ATN or data enable after done shows on the cycle done is high. The bench checks ATN again on the cycle SEL rises in the next sequence.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARB_WAIT,
    ST_ARB_SETTLE,
    ST_ARB_PRIO,
    ST_ARB_CHK2,
    ST_SEL_ON,
    ST_SEL_REL,
    ST_SEL_WAIT,
    ST_SEL_HOLD,
    ST_DONE
  } seq_state_e;

  localparam logic [1:0] RES_OK      = 2'd0;
  localparam logic [1:0] RES_ARB_TMO = 2'd1;
  localparam logic [1:0] RES_SEL_TMO = 2'd2;

endpackage

// File: rtl/busarb_timer.sv
module busarb_timer #(
  parameter int TW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load_i)     cnt_q <= val_i;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/busarb_prio.sv
module busarb_prio #(
  parameter int BUS_W = 8
) (
  input  logic [BUS_W-1:0] bus_data_i,
  input  logic [BUS_W-1:0] own_bit_i,
  output logic             lose_o
);
  logic [BUS_W-1:0] others;

  // own line removed; anything left above own value outranks it
  assign others = bus_data_i ^ own_bit_i;
  assign lose_o = (others > own_bit_i);
endmodule

// File: rtl/busarb_selmask.sv
module busarb_selmask #(
  parameter int BUS_W = 8,
  parameter int IDW   = 3
) (
  input  logic [IDW-1:0]   tgt_i,
  input  logic [BUS_W-1:0] own_bit_i,
  output logic [BUS_W-1:0] mask_o
);
  logic [BUS_W-1:0] dec;

  for (genvar g = 0; g < BUS_W; g++) begin : g_dec
    assign dec[g] = (tgt_i == IDW'(g));
  end

  assign mask_o = dec | own_bit_i;
endmodule

// File: rtl/busarb_initiator.sv
module busarb_initiator
  import busarb_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SETTLE_CYC  = 1950,
  parameter int ARB_TMO_CYC = 64000000,
  parameter int CYC_PER_MS  = 250000,
  parameter int TMO_MS_W    = 16,
  parameter int TW          = 40,
  localparam int IDW        = $clog2(BUS_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [BUS_W-1:0]    own_id_i,
  input  logic [IDW-1:0]      tgt_id_i,
  input  logic                atn_req_i,
  input  logic [TMO_MS_W-1:0] sel_tmo_ms_i,
  input  logic                bus_bsy_i,
  input  logic                bus_sel_i,
  input  logic [BUS_W-1:0]    bus_data_i,
  output logic                bsy_o,
  output logic                sel_o,
  output logic                atn_o,
  output logic [BUS_W-1:0]    data_o,
  output logic                data_oe_o,
  output logic                done_o,
  output logic [1:0]          err_o
);

  localparam logic [TW-1:0] SETTLE_LOAD = TW'(SETTLE_CYC);
  localparam logic [TW-1:0] ARB_LOAD    = TW'(ARB_TMO_CYC);
  localparam logic [TW-1:0] MS_CYC      = TW'(CYC_PER_MS);

  seq_state_e          st_q, st_d;
  logic [BUS_W-1:0]    own_q;
  logic [IDW-1:0]      tgt_q;
  logic                atn_q;
  logic [TMO_MS_W-1:0] ms_q;
  logic                lost_q, lost_clr;
  logic                atn_hold_q, atn_hold_d;
  logic [1:0]          res_q, res_d;
  logic                latch;
  logic                tmr_load, tmr_zero;
  logic [TW-1:0]       tmr_val, sel_load;
  logic                prio_lose;
  logic [BUS_W-1:0]    sel_mask_w;
  logic                in_arb, in_sel, arb_watch, lost_now;

  busarb_timer #(.TW(TW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  busarb_prio #(.BUS_W(BUS_W)) u_prio (
    .bus_data_i (bus_data_i),
    .own_bit_i  (own_q),
    .lose_o     (prio_lose)
  );

  busarb_selmask #(.BUS_W(BUS_W), .IDW(IDW)) u_mask (
    .tgt_i     (tgt_q),
    .own_bit_i (own_q),
    .mask_o    (sel_mask_w)
  );

  assign sel_load  = TW'(ms_q) * MS_CYC;
  assign in_arb    = (st_q == ST_ARB_SETTLE) || (st_q == ST_ARB_PRIO) || (st_q == ST_ARB_CHK2);
  assign in_sel    = (st_q == ST_SEL_ON) || (st_q == ST_SEL_REL) ||
                     (st_q == ST_SEL_WAIT) || (st_q == ST_SEL_HOLD);
  assign arb_watch = in_arb;
  // SEL is never driven by this block during arbitration, so any SEL seen is foreign
  assign lost_now  = lost_q || bus_sel_i;

  always_comb begin
    st_d       = st_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    lost_clr   = 1'b0;
    res_d      = res_q;
    atn_hold_d = atn_hold_q;
    latch      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          latch      = 1'b1;
          atn_hold_d = 1'b0;
          tmr_load   = 1'b1;
          tmr_val    = ARB_LOAD;
          st_d       = ST_ARB_WAIT;
        end
      end
      ST_ARB_WAIT: begin
        if (!bus_bsy_i && !bus_sel_i) begin
          lost_clr = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LOAD;
          st_d     = ST_ARB_SETTLE;
        end else if (tmr_zero) begin
          res_d = RES_ARB_TMO;
          st_d  = ST_DONE;
        end
      end
      ST_ARB_SETTLE: begin
        if (tmr_zero) begin
          if (lost_now) begin
            tmr_load = 1'b1;
            tmr_val  = ARB_LOAD;
            st_d     = ST_ARB_WAIT;
          end else begin
            st_d = ST_ARB_PRIO;
          end
        end
      end
      ST_ARB_PRIO: begin
        if (prio_lose || lost_now) begin
          tmr_load = 1'b1;
          tmr_val  = ARB_LOAD;
          st_d     = ST_ARB_WAIT;
        end else begin
          st_d = ST_ARB_CHK2;
        end
      end
      ST_ARB_CHK2: begin
        tmr_load = 1'b1;
        if (lost_now) begin
          tmr_val = ARB_LOAD;
          st_d    = ST_ARB_WAIT;
        end else begin
          tmr_val = SETTLE_LOAD;
          st_d    = ST_SEL_ON;
        end
      end
      ST_SEL_ON: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LOAD;
          st_d     = ST_SEL_REL;
        end
      end
      ST_SEL_REL: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = sel_load;
          st_d     = ST_SEL_WAIT;
        end
      end
      ST_SEL_WAIT: begin
        if (bus_bsy_i) begin
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LOAD;
          st_d     = ST_SEL_HOLD;
        end else if (tmr_zero) begin
          res_d = RES_SEL_TMO;
          st_d  = ST_DONE;
        end
      end
      ST_SEL_HOLD: begin
        if (tmr_zero) begin
          res_d      = RES_OK;
          atn_hold_d = atn_q;
          st_d       = ST_DONE;
        end
      end
      ST_DONE: begin
        res_d = RES_OK;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      own_q      <= '0;
      tgt_q      <= '0;
      atn_q      <= 1'b0;
      ms_q       <= '0;
      lost_q     <= 1'b0;
      atn_hold_q <= 1'b0;
      res_q      <= RES_OK;
    end else begin
      st_q       <= st_d;
      atn_hold_q <= atn_hold_d;
      res_q      <= res_d;
      if (latch) begin
        own_q <= own_id_i;
        tgt_q <= tgt_id_i;
        atn_q <= atn_req_i;
        ms_q  <= sel_tmo_ms_i;
      end
      if (lost_clr)                    lost_q <= 1'b0;
      else if (arb_watch && bus_sel_i) lost_q <= 1'b1;
    end
  end

  // open-collector style drives decoded from the sequence state
  assign bsy_o     = in_arb || (st_q == ST_SEL_ON);
  assign sel_o     = in_sel;
  assign atn_o     = (in_sel && atn_q) || atn_hold_q;
  assign data_oe_o = in_arb || in_sel;
  assign data_o    = in_arb ? own_q : (in_sel ? sel_mask_w : '0);
  assign done_o    = (st_q == ST_DONE);
  assign err_o     = done_o ? res_q : RES_OK;

endmodule

// File: rtl/busarb_chk.sv
module busarb_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bsy_o,
  input logic             sel_o,
  input logic             atn_o,
  input logic [BUS_W-1:0] data_o,
  input logic             data_oe_o,
  input logic             done_o,
  input logic [1:0]       err_o,
  input logic [BUS_W-1:0] sel_mask_w
);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_err_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != 2'd0) |-> done_o);

  p_timeout_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == 2'd2) |-> (!sel_o && !bsy_o && !data_oe_o && !atn_o));

  p_arb_tmo_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == 2'd1) |-> (!sel_o && !bsy_o && !data_oe_o));

  p_sel_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o |-> (data_oe_o && data_o == sel_mask_w));

  p_drive_needs_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> (bsy_o || sel_o));

  p_atn_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(atn_o) |-> sel_o);

  p_ok_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == 2'd0) |-> (!sel_o && !bsy_o && !data_oe_o));

endmodule

bind busarb_initiator busarb_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bsy_o      (bsy_o),
  .sel_o      (sel_o),
  .atn_o      (atn_o),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .sel_mask_w (sel_mask_w)
);

// File: tb/busarb_initiator_tb_top.sv
module busarb_initiator_tb_top;
  localparam int SETTLE = 3;
  localparam int ARBT   = 30;
  localparam int CPM    = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, atn_req, tgt_bsy, oth_bsy, oth_sel;
  logic [7:0]  own_id, oth_data;
  logic [2:0]  tgt_id;
  logic [15:0] tmo_ms;
  logic        bsy_o, sel_o, atn_o, data_oe_o, done_o;
  logic [7:0]  data_o;
  logic [1:0]  err_o;
  logic        bus_bsy, bus_sel;
  logic [7:0]  bus_data;

  assign bus_bsy  = bsy_o | tgt_bsy | oth_bsy;
  assign bus_sel  = sel_o | oth_sel;
  assign bus_data = (data_oe_o ? data_o : 8'h00) | oth_data;

  busarb_initiator #(.SETTLE_CYC(SETTLE), .ARB_TMO_CYC(ARBT), .CYC_PER_MS(CPM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .own_id_i(own_id), .tgt_id_i(tgt_id),
    .atn_req_i(atn_req), .sel_tmo_ms_i(tmo_ms), .bus_bsy_i(bus_bsy), .bus_sel_i(bus_sel),
    .bus_data_i(bus_data), .bsy_o(bsy_o), .sel_o(sel_o), .atn_o(atn_o), .data_o(data_o),
    .data_oe_o(data_oe_o), .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL R10 watchdog actual=%0d expected<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mask(input int own_idx, input int tgt);
    return (8'd1 << own_idx) | (8'd1 << tgt);
  endfunction

  // results of the latest run
  logic [1:0] r_err;
  logic [7:0] r_mask, r_arb_data;
  bit r_atn_sel, r_bsy_drop, r_atn_after, r_released, r_done_seen, r_done_twice;
  bit r_sel_early, r_done_early, r_arb_oe;
  int r_wait, r_attempts, r_cycles;

  task automatic run_op(input int own_idx, input int tgt, input bit atn, input bit respond,
                        input int ms, input int blk_cyc, input logic [7:0] blk_val,
                        input bit sel_pulse, input bit mid_start);
    bit prev_sel = 0, prev_bsy = 0, pulsed = 0, mid_done = 0;
    int dly = 0;
    @(negedge clk);
    own_id = 8'd1 << own_idx; tgt_id = 3'(tgt); atn_req = atn; tmo_ms = 16'(ms);
    oth_data = blk_val; start = 1'b1;
    r_err = 2'd3; r_mask = 8'h00; r_arb_data = 8'h00; r_atn_sel = 0; r_bsy_drop = 0;
    r_atn_after = 0; r_released = 0; r_done_seen = 0; r_done_twice = 0; r_sel_early = 0;
    r_done_early = 0; r_arb_oe = 0; r_wait = 0; r_attempts = 0; r_cycles = 0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      r_cycles = i;
      if (start) start = 1'b0;
      if (oth_sel) oth_sel = 1'b0;
      if (i == blk_cyc) oth_data = 8'h00;
      if (done_o) begin
        r_done_seen = 1; r_err = err_o; r_atn_after = atn_o;
        r_released = !sel_o && !bsy_o && !data_oe_o;
        r_done_early = (i < blk_cyc);
        break;
      end
      if (sel_o && i < blk_cyc) r_sel_early = 1;
      if (sel_o && !prev_sel) begin r_mask = data_o; r_atn_sel = atn_o; end
      if (bsy_o && !prev_bsy && !sel_o) begin
        if (r_attempts == 0) begin r_arb_data = data_o; r_arb_oe = data_oe_o; end
        r_attempts++;
        if (sel_pulse && !pulsed) begin oth_sel = 1'b1; pulsed = 1; end
      end
      if (sel_o && !bsy_o) begin
        r_bsy_drop = 1; r_wait++;
        if (respond) begin if (dly >= 2) tgt_bsy = 1'b1; dly++; end
        if (mid_start && !mid_done) begin start = 1'b1; mid_done = 1; end
      end
      prev_sel = sel_o; prev_bsy = bsy_o;
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    r_done_twice = done_o;
    tgt_bsy = 1'b0; oth_data = 8'h00; oth_sel = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 0; atn_req = 0; tgt_bsy = 0; oth_bsy = 0; oth_sel = 0;
    own_id = 8'h80; oth_data = 0; tgt_id = 0; tmo_ms = 16'd1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!bsy_o && !sel_o && !atn_o && !data_oe_o && !done_o && data_o == 8'h00,
        "R1 reset outputs", {bsy_o, sel_o, atn_o, data_oe_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 bus never free -> arbitration timeout
    oth_bsy = 1'b1;
    run_op(7, 0, 0, 1, 1, 0, 8'h00, 0, 0);
    oth_bsy = 1'b0;
    chk(r_done_seen && r_err == 2'd1, "R2 arb timeout code", r_err, 1);
    chk(r_attempts == 0, "R2 no drive while busy", r_attempts, 0);
    chk(r_cycles >= ARBT, "R2 timeout window", r_cycles, ARBT);
    chk(!r_done_twice, "R10 done single", r_done_twice, 0);

    // R3/R6/R7/R8 directed success with ATN
    run_op(7, 3, 1, 1, 2, 0, 8'h00, 0, 0);
    chk(r_arb_data == 8'h80 && r_arb_oe, "R3 own id during arbitration", r_arb_data, 8'h80);
    chk(r_mask == exp_mask(7, 3), "R6 select mask", r_mask, exp_mask(7, 3));
    chk(r_atn_sel, "R6 atn with sel", r_atn_sel, 1);
    chk(r_bsy_drop, "R7 bsy released while sel held", r_bsy_drop, 1);
    chk(r_err == 2'd0 && r_released, "R8 ok and released", r_err, 0);
    chk(r_atn_after, "R8 atn kept after select", r_atn_after, 1);
    repeat (5) @(negedge clk);
    chk(atn_o, "R8 atn held while idle", atn_o, 1);
    run_op(6, 1, 0, 1, 2, 0, 8'h00, 0, 0);
    chk(!r_atn_sel && !r_atn_after, "R8 atn cleared by next start", r_atn_sel, 0);
    chk(r_err == 2'd0, "R6 no-atn select ok", r_err, 0);

    // R9 selection timeout
    run_op(5, 2, 1, 0, 2, 0, 8'h00, 0, 0);
    chk(r_err == 2'd2, "R9 selection timeout code", r_err, 2);
    chk(r_released && !r_atn_after, "R9 all lines released", r_released, 1);
    chk(r_wait >= 2 * CPM, "R9 timeout window", r_wait, 2 * CPM);

    // R5/R11 higher-priority device present for many timeout windows
    run_op(2, 0, 0, 1, 2, 120, 8'h10, 0, 0);
    chk(!r_sel_early, "R5 no select while outranked", r_sel_early, 0);
    chk(!r_done_early, "R11 no error during retries", r_done_early, 0);
    chk(r_attempts > 3 && r_err == 2'd0, "R11 retries then wins", r_attempts, 4);

    // R5 lower-priority device present: wins at once
    run_op(5, 1, 0, 1, 2, 2000, 8'h03, 0, 0);
    chk(r_attempts == 1 && r_err == 2'd0, "R5 outranks lower id", r_attempts, 1);
    chk(r_mask == (exp_mask(5, 1) | 8'h03) || r_mask == exp_mask(5, 1),
        "R5 mask with lower device", r_mask, exp_mask(5, 1));

    // R4 foreign SEL during arbitration settle
    run_op(4, 6, 0, 1, 2, 0, 8'h00, 1, 0);
    chk(r_attempts >= 2, "R4 retry after lost", r_attempts, 2);
    chk(r_err == 2'd0 && r_done_seen, "R4 no error after lost", r_err, 0);

    // R10 start ignored while busy
    run_op(3, 0, 0, 1, 2, 0, 8'h00, 0, 1);
    chk(r_err == 2'd0, "R10 run with mid start ok", r_err, 0);
    begin
      int extra = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (bsy_o || done_o || sel_o) extra++;
      end
      chk(extra == 0, "R10 mid start ignored", extra, 0);
    end

    // random mix
    for (int k = 0; k < 24; k++) begin
      int oi, ti, ms;
      bit at, rs;
      oi = int'($urandom_range(7, 0));
      ti = int'($urandom_range(7, 0));
      at = 1'($urandom_range(1, 0));
      rs = 1'($urandom_range(1, 0));
      ms = int'($urandom_range(3, 1));
      run_op(oi, ti, at, rs, ms, 0, 8'h00, 0, 0);
      chk(r_mask == exp_mask(oi, ti), "R6 random mask", r_mask, exp_mask(oi, ti));
      chk(r_err == (rs ? 2'd0 : 2'd2), rs ? "R8 random ok" : "R9 random timeout",
          r_err, rs ? 0 : 2);
      chk(r_atn_after == (at && rs), "R8 random atn after", r_atn_after, at && rs);
      chk(!r_done_twice, "R10 random done single", r_done_twice, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule